// File: doc/BRIEF.md
# Teletext Request Window Generator

This block drives the request strobe that tells an upstream teletext source when to present data bits during a teletext line. A start-of-line pulse restarts a position counter that runs on the pixel clock. On a line marked as carrying teletext, the strobe is high for a contiguous window. The window opens a fixed base delay after the line start. Two 4-bit offsets, packed into one control byte, adjust the window.

The rising offset moves the whole window later. The falling offset pulls the closing edge earlier, so fewer bits are requested than the nominal 360. The closing edge is measured from the nominal end point shifted by the rising offset. When the falling offset is zero, the window therefore keeps its nominal width and slides with any change of the rising offset. A per-line counter reports how many cycles the strobe has been high since the last line start.

Control writes are staged. A written byte is applied only at the next line start, so a window in progress is never reshaped.

Top module: `ttx_req_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `ttx_req` is low and `req_count` is zero. The applied and staged control bytes both reset to 0x00.
- R2: In the control byte, bits 7:4 are the rising offset and bits 3:0 are the falling offset, each an unsigned binary count of pixel clocks from 0 to 15.
- R3: Take the cycle in which `line_start` is sampled high as cycle 0. On an active line, `ttx_req` first goes high in cycle 1 + BASE_DLY + rising offset.
- R4: On an active line, `ttx_req` stays high for exactly NOM_BITS − falling offset consecutive cycles, then goes low.
- R5: With a falling offset of zero, the window is NOM_BITS cycles wide for every rising offset. Its closing edge moves by the same amount as its opening edge.
- R6: A byte written with `cfg_we` is applied at the next `line_start`. Writes during a line leave that line's window unchanged. A write in the same cycle as `line_start` is applied at the following `line_start`.
- R7: If `ttx_line` is low in the cycle `line_start` is sampled, `ttx_req` stays low for the whole line and `req_count` stays zero.
- R8: `req_count` is cleared by `line_start` and increments once per cycle in which `ttx_req` is high. After the window closes it holds its final value until the next `line_start`.
- R9: After the window closes, `ttx_req` stays low however long the line lasts. The position counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle start-of-line pulse |
| ttx_line | input | 1 | Current line carries teletext, sampled with `line_start` |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte: rising offset in 7:4, falling offset in 3:0 |
| ttx_req | output | 1 | Teletext request strobe |
| req_count | output | $clog2(NOM_BITS+1) | Cycles of request asserted on the current line |

## Verification
The bench checks the exact opening and closing cycle of every window against bench-computed positions. An off-by-one in the counter start or in either comparison shows up as a shifted first or last high cycle, or as a width of 359 or 361.

It writes the control byte in the middle of a line and in the very cycle of `line_start`. A design that applied writes immediately would produce a reshaped or early-shifted window on those lines.

Directed sweeps of the rising offset with the falling offset at zero catch a closing edge that fails to track. A design that got this wrong would report widths other than 360.

Inactive lines and the hold after the window catch a strobe leaking onto non-teletext lines, and a position counter that wraps and reopens the window.

// File: rtl/ttx_req_gen.sv
module ttx_req_gen #(
  parameter int BASE_DLY = 24,
  parameter int NOM_BITS = 360,
  parameter int OFS_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          line_start,
  input  logic                          ttx_line,
  input  logic                          cfg_we,
  input  logic [2*OFS_W-1:0]            cfg_wdata,
  output logic                          ttx_req,
  output logic [$clog2(NOM_BITS+1)-1:0] req_count
);
  localparam int END_POS = BASE_DLY + NOM_BITS;
  localparam int CNT_MAX = END_POS + (1 << OFS_W);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(NOM_BITS + 1);

  logic [2*OFS_W-1:0] cfg_stage, cfg_live;
  logic               line_on;
  logic [CNT_W-1:0]   pos;
  logic [BIT_W-1:0]   bit_cnt;
  logic [OFS_W-1:0]   rise_ofs, fall_ofs;
  logic [CNT_W-1:0]   rise_at, fall_at;

  assign rise_ofs = cfg_live[2*OFS_W-1:OFS_W];
  assign fall_ofs = cfg_live[OFS_W-1:0];
  assign rise_at  = CNT_W'(BASE_DLY) + CNT_W'(rise_ofs);
  assign fall_at  = CNT_W'(END_POS) + CNT_W'(rise_ofs) - CNT_W'(fall_ofs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_stage <= '0;
      cfg_live  <= '0;
      line_on   <= 1'b0;
      pos       <= CNT_W'(CNT_MAX);
    end else begin
      if (cfg_we) cfg_stage <= cfg_wdata;
      if (line_start) begin
        cfg_live <= cfg_stage;
        line_on  <= ttx_line;
        pos      <= '0;
      end else if (pos != CNT_W'(CNT_MAX)) begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign ttx_req = line_on && (pos >= rise_at) && (pos < fall_at);

  always_ff @(posedge clk) begin
    if (!rst_n)          bit_cnt <= '0;
    else if (line_start) bit_cnt <= '0;
    else if (ttx_req)    bit_cnt <= bit_cnt + 1'b1;
  end

  assign req_count = bit_cnt;
endmodule

module ttx_req_gen_chk #(
  parameter int NOM_BITS = 360,
  parameter int OFS_W    = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          line_start,
  input logic                          ttx_line,
  input logic                          ttx_req,
  input logic [$clog2(NOM_BITS+1)-1:0] req_count,
  input logic [2*OFS_W-1:0]            cfg_stage,
  input logic [2*OFS_W-1:0]            cfg_live
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !ttx_req && req_count == '0);

  // R3
  rise_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ttx_req) |-> req_count == '0);

  // R4
  width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ttx_req) && !$past(line_start) |->
      int'(req_count) == NOM_BITS - int'(cfg_live[OFS_W-1:0]));

  // R6
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(cfg_live));

  // R6
  stage_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> cfg_live == $past(cfg_stage));

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !ttx_line |=> !ttx_req);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ttx_req && !line_start |=> req_count == $past(req_count) + 1'b1);

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ttx_req && !line_start |=> $stable(req_count));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(req_count) <= NOM_BITS);
endmodule

bind ttx_req_gen ttx_req_gen_chk #(.NOM_BITS(NOM_BITS), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .ttx_line(ttx_line),
  .ttx_req(ttx_req), .req_count(req_count),
  .cfg_stage(cfg_stage), .cfg_live(cfg_live)
);

// File: tb/ttx_req_gen_tb.sv
module ttx_req_gen_tb;
  localparam int BASE  = 24;
  localparam int NOM   = 360;
  localparam int LLEN  = BASE + NOM + 16 + 24;

  logic clk = 0, rst_n = 0, line_start = 0, ttx_line = 0, cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic ttx_req;
  logic [8:0] req_count;
  int n_chk = 0, n_fail = 0;
  logic [7:0] pend = 0, live = 0;

  always #5ns clk = ~clk;

  ttx_req_gen #(.BASE_DLY(BASE), .NOM_BITS(NOM), .OFS_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .ttx_line(ttx_line),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ttx_req(ttx_req), .req_count(req_count));

  function automatic int exp_first(logic [7:0] c); return BASE + int'(c[7:4]); endfunction
  function automatic int exp_width(logic [7:0] c, bit act); return act ? NOM - int'(c[3:0]) : 0; endfunction

  task automatic check(string req, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic run_line(bit act, bit wr_pre, logic [7:0] pre_v, bit wr_st, logic [7:0] st_v,
                          int mid_at, logic [7:0] mid_v, string tag);
    int first = -1, last = -1, nhi = 0;
    if (wr_pre) begin
      cfg_we = 1; cfg_wdata = pre_v; pend = pre_v;
      @(negedge clk); cfg_we = 0;
    end
    line_start = 1; ttx_line = act; live = pend;
    if (wr_st) begin cfg_we = 1; cfg_wdata = st_v; pend = st_v; end
    @(negedge clk);
    line_start = 0; ttx_line = $urandom_range(0, 1); cfg_we = 0;
    for (int i = 0; i < LLEN; i++) begin
      if (ttx_req) begin
        if (first < 0) first = i;
        last = i; nhi++;
      end
      if (i == mid_at) begin cfg_we = 1; cfg_wdata = mid_v; pend = mid_v; end
      else cfg_we = 0;
      @(negedge clk);
    end
    cfg_we = 0;
    if (act) begin
      // R3 / R2: opening position from the upper nibble
      check({"R3 first ", tag}, first, exp_first(live));
      // R4 / R5: closing position and width from the lower nibble
      check({"R4 last ", tag}, last, exp_first(live) + exp_width(live, 1) - 1);
      check({"R9 contiguous ", tag}, nhi, last - first + 1);
    end
    // R7 / R4
    check({"R7 width ", tag}, nhi, exp_width(live, act));
    // R8: count held after window
    check({"R8 count ", tag}, int'(req_count), exp_width(live, act));
  endtask

  initial begin
    #(200000 * 10ns);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1
    check("R1 req in reset", int'(ttx_req), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 req after reset", int'(ttx_req), 0);
    check("R1 count after reset", int'(req_count), 0);
    run_line(1, 0, 0, 0, 0, -1, 0, "default");
    run_line(1, 1, 8'hF0, 0, 0, -1, 0, "R5 rise15");
    run_line(1, 1, 8'h70, 0, 0, -1, 0, "R5 rise7");
    run_line(1, 1, 8'h0F, 0, 0, -1, 0, "R2 fall15");
    run_line(1, 1, 8'hFF, 0, 0, -1, 0, "R2 both15");
    run_line(1, 1, 8'h35, 0, 0, 200, 8'hC2, "R6 mid write");
    run_line(1, 0, 0, 0, 0, -1, 0, "R6 mid applied");
    run_line(1, 0, 0, 1, 8'h9A, -1, 0, "R6 write at start");
    run_line(1, 0, 0, 0, 0, -1, 0, "R6 start applied");
    run_line(0, 1, 8'h00, 0, 0, -1, 0, "R7 inactive");
    for (int k = 0; k < 24; k++) begin
      logic [7:0] v = 8'($urandom);
      run_line($urandom_range(0, 3) != 0, 1, v, 0, 0,
               ($urandom_range(0, 1) != 0) ? int'($urandom_range(0, LLEN - 1)) : -1,
               8'($urandom), "random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule